// File: doc/BRIEF.md
# Synthesizer Control I2C Write Slave

This block is a write-only I2C slave that holds the control word set of a frequency synthesizer. It oversamples SCL and SDA on the system clock and detects START and STOP conditions. It receives a device address byte, then a group-select byte, then a run of data bytes. The data bytes land in a status register, a 16-bit reference divider and a 16-bit main divider. Each group has its own fixed order, and the target advances by one register per byte.

The address byte carries one variable bit. That bit is compared with a strap pin, so two copies of the block can share one bus. The block acknowledges every byte addressed to it by pulling SDA low for the ninth clock. It stays silent for a transfer that is not addressed to it. A divider word reaches its output only when both of its bytes have arrived, so the output never holds a half-written ratio.

The control is one state machine with these states:
- IDLE: bus free.
- ADDR: receiving the address byte.
- ADDR_ACK: acknowledging the address.
- SUB: receiving the group-select byte.
- SUB_ACK: acknowledging the group select.
- DATA: receiving a data byte.
- DATA_ACK: acknowledging a data byte.
- SKIP: transfer addressed elsewhere.

Its transitions are:
- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on the falling SCL after eight bits when the address matches, and to SKIP when it does not.
- ADDR_ACK goes to SUB on the next falling SCL.
- SUB goes to SUB_ACK after eight bits.
- SUB_ACK goes to DATA on the next falling SCL.
- DATA goes to DATA_ACK after eight bits.
- DATA_ACK goes back to DATA on the next falling SCL.

Top module: `synth_ctrl_i2c`

## Requirements
- R1: After reset, every register output is zero and `sda_pull_o` is low.
- R2: An address byte is acknowledged exactly when, MSB first, it reads 1,1,0,0,1,0, then a bit equal to `addr_sel_i`, then 0.
- R3: After an address byte that does not match, the block acknowledges no byte and changes no output until the next START.
- R4: A group-select byte with bits [3:2] = 01 routes the following data bytes to the status byte, then the reference divider bits 15..8, then its bits 7..0.
- R5: A group-select byte with bits [3:2] = 11 routes the following data bytes to the main divider bits 15..8, then its bits 7..0. Bits [7:4] and [1:0] of the group-select byte have no effect.
- R6: The status byte drives the outputs as follows:
  - bits 7..4 drive `gpo_o[3:0]`.
  - bit 3 drives `band_am_o` (1 = AM, 0 = FM).
  - bit 2 drives `pd_test_o` (1 = test, 0 = analog).
  - bit 1 drives `pd_pos_o` (1 = positive polarity).
  - bit 0 drives `pd_cur1_o` (1 = current 1, 0 = current 2).
- R7: A divider output changes only when its low byte is received. A transfer that ends after the high byte leaves the output unchanged.
- R8: Data bytes beyond the last register of the selected group are acknowledged and change no output.
- R9: A group-select byte with bits [3:2] = 00 or 10 is acknowledged, and its data bytes are acknowledged and discarded.
- R10: `sda_pull_o` is high only during acknowledge clocks, and it rises only while SCL is low.
- R11: A repeated START in the middle of a transfer restarts address decoding. Data sent after it follows the new group select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| addr_sel_i | input | 1 | Strap compared with the variable address bit |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| gpo_o | output | 4 | General switching outputs from status bits 7..4 |
| band_am_o | output | 1 | Band select, 1 = AM, 0 = FM |
| pd_test_o | output | 1 | Phase detector test mode |
| pd_pos_o | output | 1 | Phase detector positive polarity |
| pd_cur1_o | output | 1 | Phase detector current 1 selected |
| ref_div_o | output | 16 | Reference divider ratio |
| main_div_o | output | 16 | Main divider ratio |

## Verification
All 256 address byte values are sent with the strap at both levels. This separates the fixed address bits, the strap comparison and the write bit from one another. All sixteen low-nibble group-select codes are then sent, each with a different upper nibble and four data bytes. This separates the routing of the two groups, the don't-care bits, the discarding of extra bytes and the mapping of a walking-one status byte. Directed transfers cover the remaining cases:
- a transfer stopped after a high byte;
- a foreign-address transfer followed by more bytes;
- a repeated START in mid-transfer.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;

    // fixed upper six bits of the device address byte
    localparam logic [5:0] DEV_ADDR_HI = 6'b110010;

    // group-select codes in bits [3:2]
    localparam logic [1:0] GRP_REF  = 2'b01;
    localparam logic [1:0] GRP_MAIN = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } ctl_state_e;

    typedef enum logic [2:0] {
        SL_STAT = 3'd0,
        SL_RHI  = 3'd1,
        SL_RLO  = 3'd2,
        SL_MHI  = 3'd3,
        SL_MLO  = 3'd4,
        SL_NONE = 3'd5
    } slot_e;

    typedef struct packed {
        logic [3:0] gpo;
        logic       band_am;
        logic       pd_test;
        logic       pd_pos;
        logic       pd_cur1;
    } stat_t;

endpackage

// File: rtl/synth_ctrl_linesync.sv
module synth_ctrl_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_o      = scl_sh[STAGES-1];
    assign sda_o      = sda_sh[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_q;
    assign scl_fall_o = ~scl_o & scl_q;
    assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/synth_ctrl_fsm.sv
module synth_ctrl_fsm
    import synth_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start,
    input  logic              stop,
    input  logic              addr_sel,
    output logic              sda_pull,
    output logic              wr_en,
    output slot_e             wr_slot,
    output logic [BYTE_W-1:0] wr_byte,
    output ctl_state_e        state_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    ctl_state_e        state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    slot_e             slot;
    logic              byte_full;
    logic              addr_ok;
    logic              receiving;
    logic              in_ack;

    assign byte_full = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_ok   = (shreg[7:2] == DEV_ADDR_HI) && (shreg[1] == addr_sel) && !shreg[0];
    assign receiving = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);

    function automatic slot_e next_slot(input slot_e s);
        unique case (s)
            SL_STAT: return SL_RHI;
            SL_RHI:  return SL_RLO;
            SL_MHI:  return SL_MLO;
            default: return SL_NONE;
        endcase
    endfunction

    // next-state decode
    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_ADDR;
        end else if (stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_SKIP:     nxt = ST_SKIP;
                ST_ADDR:     if (scl_fall && byte_full) nxt = addr_ok ? ST_ADDR_ACK : ST_SKIP;
                ST_SUB:      if (scl_fall && byte_full) nxt = ST_SUB_ACK;
                ST_DATA:     if (scl_fall && byte_full) nxt = ST_DATA_ACK;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_SUB;
                ST_SUB_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            slot    <= SL_NONE;
            wr_en   <= 1'b0;
            wr_slot <= SL_NONE;
            wr_byte <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start) begin
                bit_cnt <= '0;
            end else if (receiving && scl_rise && !byte_full) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (in_ack && scl_fall) begin
                bit_cnt <= '0;
            end
            if (!start && !stop && scl_fall && byte_full) begin
                if (state == ST_SUB) begin
                    unique case (shreg[3:2])
                        GRP_REF:  slot <= SL_STAT;
                        GRP_MAIN: slot <= SL_MHI;
                        default:  slot <= SL_NONE;
                    endcase
                end else if (state == ST_DATA) begin
                    wr_en   <= (slot != SL_NONE);
                    wr_slot <= slot;
                    wr_byte <= shreg;
                    slot    <= next_slot(slot);
                end
            end
        end
    end

    assign sda_pull = in_ack;
    assign state_o  = state;

endmodule

// File: rtl/synth_ctrl_regs.sv
module synth_ctrl_regs
    import synth_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_e             wr_slot,
    input  logic [BYTE_W-1:0] wr_byte,
    output stat_t             stat,
    output logic [DIV_W-1:0]  ref_div,
    output logic [DIV_W-1:0]  main_div
);

    logic [BYTE_W-1:0] ref_hi;
    logic [BYTE_W-1:0] main_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat     <= '0;
            ref_hi   <= '0;
            main_hi  <= '0;
            ref_div  <= '0;
            main_div <= '0;
        end else if (wr_en) begin
            unique case (wr_slot)
                SL_STAT: stat     <= stat_t'(wr_byte);
                SL_RHI:  ref_hi   <= wr_byte;
                SL_RLO:  ref_div  <= {ref_hi, wr_byte};
                SL_MHI:  main_hi  <= wr_byte;
                SL_MLO:  main_div <= {main_hi, wr_byte};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/synth_ctrl_i2c.sv
module synth_ctrl_i2c
    import synth_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel_i,
    output logic             sda_pull_o,
    output logic [3:0]       gpo_o,
    output logic             band_am_o,
    output logic             pd_test_o,
    output logic             pd_pos_o,
    output logic             pd_cur1_o,
    output logic [DIV_W-1:0] ref_div_o,
    output logic [DIV_W-1:0] main_div_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic              wr_en;
    slot_e             wr_slot;
    logic [BYTE_W-1:0] wr_byte;
    ctl_state_e        fsm_state;
    stat_t             stat_q;

    synth_ctrl_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    synth_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start    (bus_start),
        .stop     (bus_stop),
        .addr_sel (addr_sel_i),
        .sda_pull (sda_pull_o),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_byte  (wr_byte),
        .state_o  (fsm_state)
    );

    synth_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_byte  (wr_byte),
        .stat     (stat_q),
        .ref_div  (ref_div_o),
        .main_div (main_div_o)
    );

    assign gpo_o     = stat_q.gpo;
    assign band_am_o = stat_q.band_am;
    assign pd_test_o = stat_q.pd_test;
    assign pd_pos_o  = stat_q.pd_pos;
    assign pd_cur1_o = stat_q.pd_cur1;

endmodule

// File: rtl/synth_ctrl_chk.sv
module synth_ctrl_chk
    import synth_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_pull,
    input logic             wr_en,
    input slot_e            wr_slot,
    input stat_t            stat,
    input logic [DIV_W-1:0] ref_div,
    input logic [DIV_W-1:0] main_div,
    input ctl_state_e       state
);

    // R10: acknowledge drive starts only with SCL low
    a_r10_ack_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R7: reference ratio moves only on its low-byte write
    a_r7_ref_on_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_div) |-> $past(wr_en && (wr_slot == SL_RLO)));

    // R7: main ratio moves only on its low-byte write
    a_r7_main_on_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(main_div) |-> $past(wr_en && (wr_slot == SL_MLO)));

    // R4: status outputs move only on a status-slot write
    a_r4_status_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat) |-> $past(wr_en && (wr_slot == SL_STAT)));

    // R3: a foreign transfer never writes
    a_r3_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SKIP) && $past(state == ST_SKIP)) |-> !wr_en);

endmodule

bind synth_ctrl_i2c synth_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_pull (sda_pull_o),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .stat     (stat_q),
    .ref_div  (ref_div_o),
    .main_div (main_div_o),
    .state    (fsm_state)
);

// File: tb/sim_synth_ctrl_i2c.sv
module sim_synth_ctrl_i2c;

    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_line;
    logic        sda_pull;
    logic [3:0]  gpo;
    logic        band_am, pd_test, pd_pos, pd_cur1;
    logic [15:0] ref_div, main_div;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [7:0]  e_stat = '0;
    logic [15:0] e_ref = '0;
    logic [15:0] e_main = '0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    synth_ctrl_i2c u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .addr_sel_i (addr_sel),
        .sda_pull_o (sda_pull),
        .gpo_o      (gpo),
        .band_am_o  (band_am),
        .pd_test_o  (pd_test),
        .pd_pos_o   (pd_pos),
        .pd_cur1_o  (pd_cur1),
        .ref_div_o  (ref_div),
        .main_div_o (main_div)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic clean);
        clean = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1;   wq(Q);
            if (sda_pull) clean = 1'b0;
            wq(Q);
            scl = 1'b0;   wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = sda_pull;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " status"}, 32'({gpo, band_am, pd_test, pd_pos, pd_cur1}), 32'(e_stat));
        chk({tag, " ref"}, 32'(ref_div), 32'(e_ref));
        chk({tag, " main"}, 32'(main_div), 32'(e_main));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack, clean;
        logic [7:0] d [4];
        logic [7:0] sub;
        wq(5);
        rst_n = 1'b1;
        wq(4);

        // R1 reset state
        check_regs("R1");
        chk("R1 sda release", 32'(sda_pull), 32'd0);

        // R2 address sweep, both strap levels
        for (int sel = 0; sel < 2; sel++) begin
            addr_sel = sel[0];
            for (int a = 0; a < 256; a++) begin
                logic [7:0] ab;
                ab = 8'(a);
                bus_start();
                send_byte(ab, ack, clean);
                bus_stop();
                chk("R2 address ack", 32'(ack),
                    32'((ab[7:2] == 6'b110010) && (ab[1] == sel[0]) && !ab[0]));
            end
        end
        addr_sel = 1'b0;
        check_regs("R2 no write");

        // R4 R5 R6 R8 R9 group-select sweep
        for (int i = 0; i < 16; i++) begin
            sub = {4'(i * 5 + 3), 4'(i)};
            for (int k = 0; k < 4; k++) d[k] = 8'(i * 37 + k * 71 + 3);
            if (i < 8) d[0] = 8'(1 << i);
            bus_start();
            send_byte(8'hC8, ack, clean);
            chk("R2 ack", 32'(ack), 32'd1);
            send_byte(sub, ack, clean);
            chk("R9 sub ack", 32'(ack), 32'd1);
            for (int k = 0; k < 4; k++) begin
                send_byte(d[k], ack, clean);
                chk("R8 data ack", 32'(ack), 32'd1);
                chk("R10 no pull in data bits", 32'(clean), 32'd1);
            end
            bus_stop();
            chk("R10 released after stop", 32'(sda_pull), 32'd0);
            if (sub[3:2] == 2'b01) begin
                e_stat = d[0];
                e_ref  = {d[1], d[2]};
                check_regs("R4 R6 R8");
            end else if (sub[3:2] == 2'b11) begin
                e_main = {d[0], d[1]};
                check_regs("R5 R8");
            end else begin
                check_regs("R9");
            end
        end

        // R7 transfers stopped after the high byte
        bus_start();
        send_byte(8'hC8, ack, clean);
        send_byte(8'h04, ack, clean);
        send_byte(8'h5A, ack, clean);
        send_byte(8'hAB, ack, clean);
        bus_stop();
        e_stat = 8'h5A;
        check_regs("R7 ref half");
        bus_start();
        send_byte(8'hC8, ack, clean);
        send_byte(8'h0C, ack, clean);
        send_byte(8'hCD, ack, clean);
        bus_stop();
        check_regs("R7 main half");

        // R3 strap high, foreign address then more bytes
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'hC8, ack, clean);
        chk("R3 addr nack", 32'(ack), 32'd0);
        send_byte(8'h0C, ack, clean);
        chk("R3 sub nack", 32'(ack), 32'd0);
        send_byte(8'h11, ack, clean);
        chk("R3 data nack", 32'(ack), 32'd0);
        send_byte(8'h22, ack, clean);
        chk("R3 data nack", 32'(ack), 32'd0);
        bus_stop();
        check_regs("R3 unchanged");
        bus_start();
        send_byte(8'hCA, ack, clean);
        chk("R2 strap high ack", 32'(ack), 32'd1);
        send_byte(8'hFC, ack, clean);
        send_byte(8'hFF, ack, clean);
        send_byte(8'hFE, ack, clean);
        bus_stop();
        e_main = 16'hFFFE;
        check_regs("R5 strap high");
        addr_sel = 1'b0;

        // R11 repeated start mid-transfer switches group
        bus_start();
        send_byte(8'hC8, ack, clean);
        send_byte(8'h0C, ack, clean);
        send_byte(8'h12, ack, clean);
        bus_start();
        send_byte(8'hC8, ack, clean);
        chk("R11 readdress ack", 32'(ack), 32'd1);
        send_byte(8'h04, ack, clean);
        send_byte(8'hA5, ack, clean);
        send_byte(8'h34, ack, clean);
        send_byte(8'h56, ack, clean);
        bus_stop();
        e_stat = 8'hA5;
        e_ref  = 16'h3456;
        check_regs("R11");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule